// File: doc/BRIEF.md
# Receive FIFO Flow Control Hysteresis

This block watches the fill level of a local receive FIFO and throttles the far-end transmitter before the FIFO overflows. Two marks form a hysteresis band. When the level climbs to the high mark, the block enters a throttled state. It leaves that state only when the level has drained below the low mark. Because the band lies between the marks, the flow signalling does not chatter when the level sits near a single threshold.

The same throttled state drives two kinds of throttling, and each is enabled on its own.

- **In-band:** the block raises a one-shot request to send an XOFF or an XON character. The request stays pending until the transmitter acknowledges that the character went out.
- **Out-of-band:** the active-low RTS and DTR lines are released while throttled. Each line is released only if its control is enabled.

In enhanced mode, the marks come from two programmable registers. In legacy mode, a 2-bit trigger field picks a fixed high mark, and the low mark is derived from it.

Top module: `rxfc_hyst_top`

## Requirements
- R1: After reset, and in any cycle after one in which in-band, RTS and DTR flow control are all disabled, no request is pending, the throttled state is clear, and `rts_n` and `dtr_n` are driven 0.
- R2: With flow control enabled and the state not throttled, a level at or above the effective high mark enters the throttled state. If in-band is enabled, `xoff_req` rises one cycle later. Only one XOFF is requested per crossing.
- R3: While throttled, a level below the effective low mark leaves the throttled state. If in-band is enabled, `xon_req` rises one cycle later. Only one XON is requested per crossing.
- R4: In enhanced mode, a programmed low mark of 0 is treated as 1.
- R5: When `rts_auto_en` is 1, `rts_n` is 1 exactly while the throttled state is set, one cycle after each transition. When `rts_auto_en` is 0, `rts_n` is 0 the next cycle.
- R6: `dtr_n` follows the throttled state like `rts_n` only when `dtr_mode` equals 2'b01. Any other code keeps `dtr_n` at 0.
- R7: With `enh_mode` at 0, the high mark is (2·T+1)·DEPTH/8 for trigger code T, and the low mark is half of it. With the default DEPTH of 128, that gives 16/8, 48/24, 80/40 and 112/56.
- R8: A pending request stays set until `tx_flow_ack` is sampled high in a cycle with no new crossing. It clears in the following cycle.
- R9: A pending XOFF is replaced by XON when the level falls below the low mark before the acknowledge arrives. A pending XON is likewise replaced by XOFF on a new high crossing.
- R10: With `inband_en` at 0, both request outputs are 0 one cycle later, even while out-of-band throttling is active.
- R11: `xoff_req` and `xon_req` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| hi_mark | input | THR_W | Programmed high mark (enhanced mode) |
| lo_mark | input | THR_W | Programmed low mark (enhanced mode), 0 treated as 1 |
| enh_mode | input | 1 | 1 selects programmed marks, 0 selects the legacy trigger field |
| legacy_trig | input | 2 | Legacy high-mark selector |
| inband_en | input | 1 | Enables XOFF/XON requests |
| rts_auto_en | input | 1 | Enables automatic RTS throttling |
| dtr_mode | input | 2 | DTR configuration; 2'b01 selects receive flow throttling |
| tx_flow_ack | input | 1 | Transmitter has sent the pending flow character |
| xoff_req | output | 1 | Pending request to send XOFF |
| xon_req | output | 1 | Pending request to send XON |
| rts_n | output | 1 | Active-low RTS, 1 while throttled and enabled |
| dtr_n | output | 1 | Active-low DTR, 1 while throttled and enabled |

## Verification
Every output is one register away from the throttled flag or the request state, so a wrong internal state shows at the ports one cycle after the level sample that exposes it. A missed or duplicated crossing appears as a request edge in the wrong cycle, or as a second pulse after an acknowledge. A wrong mark shifts the `rts_n` transition by a whole level step during a ramp. Ramps that go up and then down, run against a per-cycle reference model, therefore localise any band or mark error to the exact level where it occurs.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  // Pending flow character request
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_XOFF = 2'b01,
    REQ_XON  = 2'b10
  } req_e;

  // DTR configuration code that hands the line to receive flow control
  localparam logic [1:0] DTR_RX_FLOW = 2'b01;

  // Indices of the out-of-band lines
  localparam int LINE_RTS = 0;
  localparam int LINE_DTR = 1;
  localparam int N_LINES  = 2;

endpackage

// File: rtl/rxfc_mark_sel.sv
module rxfc_mark_sel #(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic             enh_mode,
  input  logic [1:0]       legacy_trig,
  input  logic [THR_W-1:0] hi_mark,
  input  logic [THR_W-1:0] lo_mark,
  output logic [LVL_W-1:0] eff_hi,
  output logic [LVL_W-1:0] eff_lo
);

  localparam int STEP = DEPTH / 8;

  logic [LVL_W-1:0] leg_hi;
  logic [LVL_W-1:0] leg_lo;
  logic [LVL_W-1:0] prog_lo;

  // Legacy marks: odd multiples of an eighth, low mark at half
  always_comb begin
    leg_hi = LVL_W'((32'(legacy_trig) * 2 + 1) * STEP);
    leg_lo = leg_hi >> 1;
  end

  // A zero low mark cannot be crossed from above; lift it to 1
  always_comb begin
    if (lo_mark == '0) prog_lo = LVL_W'(1);
    else               prog_lo = LVL_W'(lo_mark);
  end

  always_comb begin
    if (enh_mode) begin
      eff_hi = LVL_W'(hi_mark);
      eff_lo = prog_lo;
    end else begin
      eff_hi = leg_hi;
      eff_lo = leg_lo;
    end
  end

endmodule

// File: rtl/rxfc_band.sv
module rxfc_band #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flow_on,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] eff_hi,
  input  logic [LVL_W-1:0] eff_lo,
  output logic             set_ev,
  output logic             clr_ev,
  output logic             thr_next
);

  logic thr_q;

  always_comb begin
    set_ev = flow_on && !thr_q && (rx_level >= eff_hi);
    clr_ev = flow_on &&  thr_q && (rx_level <  eff_lo);
  end

  always_comb begin
    if (!flow_on)    thr_next = 1'b0;
    else if (set_ev) thr_next = 1'b1;
    else if (clr_ev) thr_next = 1'b0;
    else             thr_next = thr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) thr_q <= 1'b0;
    else     thr_q <= thr_next;
  end

endmodule

// File: rtl/rxfc_req.sv
module rxfc_req
  import rxfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inband_en,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic ack,
  output logic xoff_req,
  output logic xon_req
);

  req_e req_q;
  req_e req_d;

  // A new crossing overrides whatever is pending; ack only clears
  always_comb begin
    req_d = req_q;
    if (!inband_en)  req_d = REQ_NONE;
    else if (set_ev) req_d = REQ_XOFF;
    else if (clr_ev) req_d = REQ_XON;
    else if (ack)    req_d = REQ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= REQ_NONE;
    else     req_q <= req_d;
  end

  assign xoff_req = (req_q == REQ_XOFF);
  assign xon_req  = (req_q == REQ_XON);

endmodule

// File: rtl/rxfc_line.sv
module rxfc_line (
  input  logic clk,
  input  logic rst,
  input  logic line_en,
  input  logic thr_next,
  output logic line_n
);

  // Active-low modem line: released (1) while throttled
  always_ff @(posedge clk) begin
    if (rst) line_n <= 1'b0;
    else     line_n <= line_en && thr_next;
  end

endmodule

// File: rtl/rxfc_hyst_top.sv
module rxfc_hyst_top
  import rxfc_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [THR_W-1:0] hi_mark,
  input  logic [THR_W-1:0] lo_mark,
  input  logic             enh_mode,
  input  logic [1:0]       legacy_trig,
  input  logic             inband_en,
  input  logic             rts_auto_en,
  input  logic [1:0]       dtr_mode,
  input  logic             tx_flow_ack,
  output logic             xoff_req,
  output logic             xon_req,
  output logic             rts_n,
  output logic             dtr_n
);

  logic [LVL_W-1:0]   eff_hi;
  logic [LVL_W-1:0]   eff_lo;
  logic               set_ev;
  logic               clr_ev;
  logic               thr_next;
  logic               dtr_flow;
  logic               flow_on;
  logic [N_LINES-1:0] line_en;
  logic [N_LINES-1:0] line_n;

  assign dtr_flow = (dtr_mode == DTR_RX_FLOW);
  assign flow_on  = inband_en || rts_auto_en || dtr_flow;

  always_comb begin
    line_en           = '0;
    line_en[LINE_RTS] = rts_auto_en;
    line_en[LINE_DTR] = dtr_flow;
  end

  rxfc_mark_sel #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W),
    .THR_W (THR_W)
  ) mark_i (
    .enh_mode    (enh_mode),
    .legacy_trig (legacy_trig),
    .hi_mark     (hi_mark),
    .lo_mark     (lo_mark),
    .eff_hi      (eff_hi),
    .eff_lo      (eff_lo)
  );

  rxfc_band #(
    .LVL_W (LVL_W)
  ) band_i (
    .clk      (clk),
    .rst      (rst),
    .flow_on  (flow_on),
    .rx_level (rx_level),
    .eff_hi   (eff_hi),
    .eff_lo   (eff_lo),
    .set_ev   (set_ev),
    .clr_ev   (clr_ev),
    .thr_next (thr_next)
  );

  rxfc_req req_i (
    .clk       (clk),
    .rst       (rst),
    .inband_en (inband_en),
    .set_ev    (set_ev),
    .clr_ev    (clr_ev),
    .ack       (tx_flow_ack),
    .xoff_req  (xoff_req),
    .xon_req   (xon_req)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    rxfc_line line_i (
      .clk      (clk),
      .rst      (rst),
      .line_en  (line_en[g]),
      .thr_next (thr_next),
      .line_n   (line_n[g])
    );
  end

  assign rts_n = line_n[LINE_RTS];
  assign dtr_n = line_n[LINE_DTR];

endmodule

// File: rtl/rxfc_hyst_chk.sv
module rxfc_hyst_chk #(
  parameter int LVL_W = 8,
  parameter int THR_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] rx_level,
  input logic [THR_W-1:0] hi_mark,
  input logic [THR_W-1:0] lo_mark,
  input logic             enh_mode,
  input logic             inband_en,
  input logic             rts_auto_en,
  input logic             tx_flow_ack,
  input logic             xoff_req,
  input logic             xon_req,
  input logic             rts_n
);

  logic [LVL_W-1:0] prog_lo;
  assign prog_lo = (lo_mark == '0) ? LVL_W'(1) : LVL_W'(lo_mark);

  // R11
  one_request_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xoff_req, xon_req}));

  // R10
  inband_off_chk: assert property (@(posedge clk) disable iff (rst)
    !inband_en |=> (!xoff_req && !xon_req));

  // R5
  rts_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !rts_auto_en |=> !rts_n);

  // R8
  xoff_held_chk: assert property (@(posedge clk) disable iff (rst)
    (xoff_req && !tx_flow_ack && inband_en && enh_mode && rx_level >= prog_lo)
      |=> xoff_req);

  // R8
  xon_acked_chk: assert property (@(posedge clk) disable iff (rst)
    (xon_req && tx_flow_ack && enh_mode && rx_level < LVL_W'(hi_mark))
      |=> !xon_req);

  // R4
  zero_lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rts_n && rts_auto_en && enh_mode && lo_mark == '0 && rx_level != '0)
      |=> rts_n);

endmodule

bind rxfc_hyst_top rxfc_hyst_chk #(
  .LVL_W (LVL_W),
  .THR_W (THR_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rx_level    (rx_level),
  .hi_mark     (hi_mark),
  .lo_mark     (lo_mark),
  .enh_mode    (enh_mode),
  .inband_en   (inband_en),
  .rts_auto_en (rts_auto_en),
  .tx_flow_ack (tx_flow_ack),
  .xoff_req    (xoff_req),
  .xon_req     (xon_req),
  .rts_n       (rts_n)
);

// File: tb/rxfc_hyst_top_tb.sv
module rxfc_hyst_top_tb_top;

  localparam int DEPTH = 128;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int THR_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] rx_level = '0;
  logic [THR_W-1:0] hi_mark = '0;
  logic [THR_W-1:0] lo_mark = '0;
  logic             enh_mode = 1'b1;
  logic [1:0]       legacy_trig = '0;
  logic             inband_en = 1'b0;
  logic             rts_auto_en = 1'b0;
  logic [1:0]       dtr_mode = '0;
  logic             tx_flow_ack = 1'b0;
  logic             xoff_req, xon_req, rts_n, dtr_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  bit m_thr = 0, m_xoff = 0, m_xon = 0, m_rts = 0, m_dtr = 0;

  always #10 clk = ~clk;

  rxfc_hyst_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .rx_level(rx_level), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .enh_mode(enh_mode), .legacy_trig(legacy_trig),
    .inband_en(inband_en), .rts_auto_en(rts_auto_en), .dtr_mode(dtr_mode),
    .tx_flow_ack(tx_flow_ack), .xoff_req(xoff_req), .xon_req(xon_req),
    .rts_n(rts_n), .dtr_n(dtr_n)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (level=%0d)",
               tag, what, act, exp, rx_level);
    end
  endtask

  // Reference model from the requirements, evaluated at each rising edge
  task automatic model_step();
    int hi, lo;
    bit on, set, clr;
    if (enh_mode) begin
      hi = int'(hi_mark);
      lo = (lo_mark == 0) ? 1 : int'(lo_mark);
    end else begin
      hi = (2 * int'(legacy_trig) + 1) * (DEPTH / 8);
      lo = hi / 2;
    end
    on = inband_en || rts_auto_en || (dtr_mode == 2'b01);
    if (rst || !on) begin
      m_thr = 0; m_xoff = 0; m_xon = 0;
    end else begin
      set = !m_thr && int'(rx_level) >= hi;
      clr =  m_thr && int'(rx_level) <  lo;
      if (!inband_en)     begin m_xoff = 0; m_xon = 0; end
      else if (set)       begin m_xoff = 1; m_xon = 0; end
      else if (clr)       begin m_xoff = 0; m_xon = 1; end
      else if (tx_flow_ack) begin m_xoff = 0; m_xon = 0; end
      if (set) m_thr = 1;
      else if (clr) m_thr = 0;
    end
    m_rts = !rst && m_thr && rts_auto_en;
    m_dtr = !rst && m_thr && (dtr_mode == 2'b01);
  endtask

  // Inputs are set at a falling edge; outputs compared at the next one
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "xoff_req", int'(xoff_req), int'(m_xoff));
    chk(tag, "xon_req", int'(xon_req), int'(m_xon));
    chk(tag, "rts_n", int'(rts_n), int'(m_rts));
    chk(tag, "dtr_n", int'(dtr_n), int'(m_dtr));
    chk({tag, " R11"}, "both_req", int'(xoff_req && xon_req), 0);
  endtask

  // Ramp the level up to full and back to empty; ack pattern by mode
  task automatic ramp(string tag, int ack_mode);
    for (int i = 0; i <= 2 * DEPTH; i++) begin
      int lv = (i <= DEPTH) ? i : 2 * DEPTH - i;
      rx_level    = LVL_W'(lv);
      tx_flow_ack = (ack_mode == 1) || (ack_mode == 2 && (i % 3) == 0);
      cyc(tag);
    end
    tx_flow_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hs[5] = '{10, 64, 127, 1, 40};
    int ls[5] = '{5, 0, 100, 1, 39};
    @(negedge clk);
    // R1 reset state, even with enables on
    inband_en = 1; rts_auto_en = 1; dtr_mode = 2'b01;
    rx_level = LVL_W'(DEPTH);
    repeat (3) cyc("R1 reset");
    rst = 0; rx_level = '0;
    cyc("R1 after reset");

    // R2 R3 R5 R8 R9 enhanced sweeps with several ack patterns
    for (int p = 0; p < 5; p++) begin
      hi_mark = THR_W'(hs[p]); lo_mark = THR_W'(ls[p]);
      for (int a = 0; a < 3; a++) ramp("R2 R3 R5 R8 R9 enhanced", a);
    end

    // R4 zero low mark: resume only at level 0
    hi_mark = 7'd20; lo_mark = '0;
    rx_level = 8'd25; cyc("R4 set");
    rx_level = 8'd1;  repeat (3) cyc("R4 hold at 1");
    chk("R4", "rts_n at level 1", int'(rts_n), 1);
    rx_level = 8'd0;  cyc("R4 release at 0");
    chk("R4", "rts_n at level 0", int'(rts_n), 0);

    // R6 R10 DTR codes with in-band off
    inband_en = 0; rts_auto_en = 0;
    hi_mark = 7'd30; lo_mark = 7'd10;
    for (int d = 0; d < 4; d++) begin
      dtr_mode = 2'(d);
      ramp("R6 R10 dtr code", 2);
    end

    // R5 RTS alone
    dtr_mode = 2'b00; rts_auto_en = 1;
    ramp("R5 rts only", 0);

    // R7 legacy marks
    enh_mode = 0; inband_en = 1; dtr_mode = 2'b01;
    for (int t = 0; t < 4; t++) begin
      legacy_trig = 2'(t);
      ramp("R7 legacy", 2);
    end

    // R1 disable while throttled
    enh_mode = 1; hi_mark = 7'd50; lo_mark = 7'd20;
    rx_level = 8'd60; cyc("R1 throttle");
    chk("R1", "rts_n throttled", int'(rts_n), 1);
    inband_en = 0; rts_auto_en = 0; dtr_mode = 2'b00;
    cyc("R1 disable");
    chk("R1", "xoff_req cleared", int'(xoff_req), 0);
    chk("R1", "rts_n asserted", int'(rts_n), 0);
    // Re-enable while still above the mark: a fresh crossing
    inband_en = 1;
    cyc("R1 R2 re-enable");
    chk("R2", "xoff_req again", int'(xoff_req), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule